// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Controller

This block gathers up to 64 level-type interrupt sources and presents them to one or two processors. Each processor owns its own bank of mask bits. A source is pending for a processor when its level input is high and that processor's mask bit for it is set. No source outranks another. Each processor has a resume pointer. The search for a pending source starts at that pointer and wraps around the source count. When the processor acknowledges a request, its pointer moves just past the source it was given.

Software reaches the mask banks through 32-bit words on a small read/write port. In 64-source mode the two words are stored in swapped order. A single-source mask operation clears a source's bit in every bank. A single-source unmask operation sets the bit in the banks selected by a processor-enable vector and clears it in the rest.

A contiguous slice of source indices can carry cascaded external lines. When the selected source falls in that slice, the index is reported relative to the start of the slice and a flag marks it as external.

Top module: `rr_irq_ctrl`

## Requirements
- R1: A source is pending for a processor only when its `src_stat` bit and that processor's mask bit are both 1. `cpuN_req` is high only while some source is pending for processor N.
- R2: After reset, all mask bits read 0, both pointers are 0 and neither request is high.
- R3: Mask register word w, bit b, holds source `((w XOR (NUM_SRC/32 - 1)) * 32) + b`. With 64 sources, word 0 therefore holds sources 32..63 and word 1 holds sources 0..31. A write to the word replaces those 32 bits, and a read returns them.
- R4: The source selected for a processor is the first pending source found when counting upward from that processor's pointer, wrapping modulo NUM_SRC.
- R5: On a clock edge where `cpuN_ack` and `cpuN_req` are both high, processor N's pointer becomes (selected index + 1) modulo NUM_SRC.
- R6: While nothing is pending for a processor, its request is low and its pointer does not change, even if its acknowledge is pulsed.
- R7: A mask operation (`op_valid` high, `op_unmask` low) clears the source's bit in every present bank.
- R8: An unmask operation sets the source's bit in bank N when `op_cpu_en[N]` is 1 and clears it when `op_cpu_en[N]` is 0.
- R9: When the selected index lies in [CASC_LO, CASC_HI], `cpuN_ext` is 1 and `cpuN_idx` is the index minus CASC_LO. Otherwise `cpuN_ext` is 0 and `cpuN_idx` is the raw index.
- R10: With HAS_CPU1 = 0, writes to bank 1 have no effect, bank 1 reads back 0 and `cpu1_req` stays low.
- R11: If a register write and a single-source operation arrive in the same cycle, the operation decides the bit it names. The write decides the other bits of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_stat | input | NUM_SRC | Level of each interrupt source |
| reg_wr | input | 1 | Write strobe for a mask word |
| reg_cpu | input | 1 | Bank addressed by read and write |
| reg_word | input | WW | Word address inside the bank |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word |
| op_valid | input | 1 | Single-source mask/unmask strobe |
| op_unmask | input | 1 | 1 = unmask, 0 = mask |
| op_src | input | IDXW | Source index for the operation |
| op_cpu_en | input | 2 | Per-processor enable for an unmask |
| cpu0_req | output | 1 | Processor 0 has a pending source |
| cpu0_idx | output | IDXW | Processor 0 selected index (remapped if external) |
| cpu0_ext | output | 1 | Processor 0 index is a cascaded external line |
| cpu0_ack | input | 1 | Processor 0 takes the request |
| cpu1_req | output | 1 | Processor 1 has a pending source |
| cpu1_idx | output | IDXW | Processor 1 selected index (remapped if external) |
| cpu1_ext | output | 1 | Processor 1 index is a cascaded external line |
| cpu1_ack | input | 1 | Processor 1 takes the request |

## Verification
The bench targets the following corner cases.

- **Pointer wrap.** The search wraps from index 63 back to 0, and the pointer wraps when index 63 is served. A controller that saturated the pointer, or searched from 0 every time, would serve the wrong source.
- **Acknowledge with nothing pending.** An acknowledge pulse arrives while nothing is pending. A design that moved its pointer anyway would pick a different source on the next pattern.
- **Word order.** The swapped word order is checked by unmasking only word 0 and expecting source 32. An unswapped design would report source 0.
- **Cascade boundaries.** Selections at both ends of the cascade slice and just past it are checked. An off-by-one range test would misflag index 12 or index 8.
- **Unmask routing and write collisions.** Per-processor unmask routing is checked, a write colliding with an operation is checked, and a build with one processor is checked. A design that leaked state into the absent bank would raise a request there.

// File: rtl/rr_irq_ctrl.sv
module rr_irq_ctrl #(
  parameter int NUM_SRC  = 64,
  parameter bit HAS_CPU1 = 1'b1,
  parameter int CASC_LO  = 8,
  parameter int CASC_HI  = 11,
  localparam int WORDS   = NUM_SRC / 32,
  localparam int WW      = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int IDXW    = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_stat,
  input  logic              reg_wr,
  input  logic              reg_cpu,
  input  logic [WW-1:0]     reg_word,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              op_valid,
  input  logic              op_unmask,
  input  logic [IDXW-1:0]   op_src,
  input  logic [1:0]        op_cpu_en,
  output logic              cpu0_req,
  output logic [IDXW-1:0]   cpu0_idx,
  output logic              cpu0_ext,
  input  logic              cpu0_ack,
  output logic              cpu1_req,
  output logic [IDXW-1:0]   cpu1_idx,
  output logic              cpu1_ext,
  input  logic              cpu1_ack
);

  logic [NUM_SRC-1:0] mask_q [2];
  logic [NUM_SRC-1:0] mask_d [2];
  logic [NUM_SRC-1:0] pend   [2];
  logic [IDXW-1:0]    ptr_q  [2];
  logic [IDXW-1:0]    sel    [2];
  logic [1:0]         found;
  logic [1:0]         ack;
  logic [1:0]         present;
  logic [1:0]         ext;
  int                 rbase;

  assign present = {HAS_CPU1, 1'b1};
  assign ack     = {cpu1_ack, cpu0_ack};
  assign rbase   = ((int'(reg_word) ^ (WORDS - 1)) % WORDS) * 32;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      mask_d[c] = mask_q[c];
      if (reg_wr && (int'(reg_cpu) == c))
        for (int b = 0; b < 32; b++) mask_d[c][rbase + b] = reg_wdata[b];
      if (op_valid) mask_d[c][op_src] = op_unmask & op_cpu_en[c];
      if (!present[c]) mask_d[c] = '0;
    end
  end

  always_comb begin
    for (int b = 0; b < 32; b++) reg_rdata[b] = mask_q[reg_cpu][rbase + b];
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      pend[c]  = src_stat & mask_q[c];
      found[c] = 1'b0;
      sel[c]   = '0;
      for (int k = NUM_SRC - 1; k >= 0; k--) begin
        if (pend[c][ptr_q[c] + IDXW'(k)]) begin
          found[c] = 1'b1;
          sel[c]   = ptr_q[c] + IDXW'(k);
        end
      end
      ext[c] = found[c] && (int'(sel[c]) >= CASC_LO) && (int'(sel[c]) <= CASC_HI);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        mask_q[c] <= '0;
        ptr_q[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        mask_q[c] <= mask_d[c];
        if (ack[c] && found[c]) ptr_q[c] <= sel[c] + 1'b1;
      end
    end
  end

  assign cpu0_req = found[0];
  assign cpu1_req = found[1];
  assign cpu0_ext = ext[0];
  assign cpu1_ext = ext[1];
  assign cpu0_idx = ext[0] ? sel[0] - IDXW'(CASC_LO) : sel[0];
  assign cpu1_idx = ext[1] ? sel[1] - IDXW'(CASC_LO) : sel[1];

  AST_REQ_PENDING0: assert property (@(posedge clk) disable iff (!rst_n) cpu0_req |-> pend[0][sel[0]]); // R1
  AST_REQ_PENDING1: assert property (@(posedge clk) disable iff (!rst_n) cpu1_req |-> pend[1][sel[1]]); // R1
  AST_IDLE_NOREQ0:  assert property (@(posedge clk) disable iff (!rst_n) (pend[0] == '0) |-> !cpu0_req); // R6
  AST_PTR_STEP0:    assert property (@(posedge clk) disable iff (!rst_n) (cpu0_req && cpu0_ack) |=> ptr_q[0] == IDXW'($past(sel[0]) + 1'b1)); // R5
  AST_PTR_STEP1:    assert property (@(posedge clk) disable iff (!rst_n) (cpu1_req && cpu1_ack) |=> ptr_q[1] == IDXW'($past(sel[1]) + 1'b1)); // R5
  AST_PTR_HOLD0:    assert property (@(posedge clk) disable iff (!rst_n) !(cpu0_req && cpu0_ack) |=> $stable(ptr_q[0])); // R6
  AST_PTR_HOLD1:    assert property (@(posedge clk) disable iff (!rst_n) !(cpu1_req && cpu1_ack) |=> $stable(ptr_q[1])); // R6
  AST_MASK_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) (op_valid && !op_unmask) |=> !mask_q[0][$past(op_src)] && !mask_q[1][$past(op_src)]); // R7
  AST_EXT_RANGE0:   assert property (@(posedge clk) disable iff (!rst_n) cpu0_ext |-> int'(cpu0_idx) <= CASC_HI - CASC_LO); // R9

endmodule

// File: tb/test_rr_irq_ctrl.sv
module test_rr_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [63:0] src_stat = '0;
  logic reg_wr = 0, reg_cpu = 0;
  logic [0:0] reg_word = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic op_valid = 0, op_unmask = 0;
  logic [5:0] op_src = '0;
  logic [1:0] op_cpu_en = '0;
  logic cpu0_req, cpu0_ext, cpu1_req, cpu1_ext;
  logic [5:0] cpu0_idx, cpu1_idx;
  logic cpu0_ack = 0, cpu1_ack = 0;

  logic [31:0] s_stat = '0;
  logic s_wr = 0, s_cpu = 0;
  logic [0:0] s_word = '0;
  logic [31:0] s_wdata = '0, s_rdata;
  logic s_req0, s_ext0, s_req1, s_ext1;
  logic [4:0] s_idx0, s_idx1;

  int n_run = 0, n_fail = 0;

  rr_irq_ctrl i_rr_irq_ctrl (
    .clk, .rst_n, .src_stat, .reg_wr, .reg_cpu, .reg_word, .reg_wdata, .reg_rdata,
    .op_valid, .op_unmask, .op_src, .op_cpu_en,
    .cpu0_req, .cpu0_idx, .cpu0_ext, .cpu0_ack,
    .cpu1_req, .cpu1_idx, .cpu1_ext, .cpu1_ack);

  rr_irq_ctrl #(.NUM_SRC(32), .HAS_CPU1(1'b0)) i_rr_irq_ctrl_solo (
    .clk, .rst_n, .src_stat(s_stat), .reg_wr(s_wr), .reg_cpu(s_cpu), .reg_word(s_word),
    .reg_wdata(s_wdata), .reg_rdata(s_rdata),
    .op_valid(1'b0), .op_unmask(1'b0), .op_src(5'd0), .op_cpu_en(2'b00),
    .cpu0_req(s_req0), .cpu0_idx(s_idx0), .cpu0_ext(s_ext0), .cpu0_ack(1'b0),
    .cpu1_req(s_req1), .cpu1_idx(s_idx1), .cpu1_ext(s_ext1), .cpu1_ack(1'b0));

  // {status[63:0], req, idx[5:0], ext}; R4 R5 R9 walk with pointer starting at 0
  localparam logic [71:0] VEC [11] = '{
    {64'h0000_0100_0000_0020, 1'b1, 6'd5,  1'b0},
    {64'h0000_0100_0000_0020, 1'b1, 6'd40, 1'b0},
    {64'h0000_0100_0000_0020, 1'b1, 6'd5,  1'b0},
    {64'h0000_0000_0000_0208, 1'b1, 6'd1,  1'b1},
    {64'h8000_0000_0000_0001, 1'b1, 6'd63, 1'b0},
    {64'h8000_0000_0000_0001, 1'b1, 6'd0,  1'b0},
    {64'h0000_0000_0000_0000, 1'b0, 6'd0,  1'b0},
    {64'h0000_0000_0000_0002, 1'b1, 6'd1,  1'b0},
    {64'h0000_0000_0000_1800, 1'b1, 6'd3,  1'b1},
    {64'h0000_0000_0000_1800, 1'b1, 6'd12, 1'b0},
    {64'h0000_0000_0000_0100, 1'b1, 6'd0,  1'b1}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic cpu, input logic w, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_cpu = cpu; reg_word = w; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic cpu, input logic w, output logic [31:0] d);
    @(negedge clk); reg_cpu = cpu; reg_word = w; #1 d = reg_rdata;
  endtask

  task automatic op(input logic um, input logic [5:0] s, input logic [1:0] en);
    @(negedge clk); op_valid = 1; op_unmask = um; op_src = s; op_cpu_en = en;
    @(negedge clk); op_valid = 0;
  endtask

  task automatic ack0();
    @(negedge clk); cpu0_ack = 1;
    @(negedge clk); cpu0_ack = 0;
  endtask

  task automatic stat(input logic [63:0] s);
    @(negedge clk); src_stat = s; #2;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    stat('1);
    chk("R2 no req after reset", {62'd0, cpu1_req, cpu0_req}, 64'd0);
    rd(0, 0, r); chk("R2 mask reads 0", r, 0);
    chk("R1 masked sources raise no req", cpu0_req, 0);

    wr(0, 0, 32'hffff_ffff);
    wr(0, 1, 32'hffff_ffff);
    for (int i = 0; i < 11; i++) begin
      stat(VEC[i][71:8]);
      chk($sformatf("R4 vec%0d req", i), cpu0_req, VEC[i][7]);
      if (VEC[i][7]) begin
        chk($sformatf("R4 R9 vec%0d idx", i), cpu0_idx, VEC[i][6:1]);
        chk($sformatf("R9 vec%0d ext", i), cpu0_ext, VEC[i][0]);
        ack0();
      end
    end

    // pointer is 9 here
    stat(64'h80);
    chk("R4 wrap to 7", cpu0_idx, 7);
    ack0();
    stat(64'h0);
    chk("R6 no req", cpu0_req, 0);
    ack0();
    stat(64'h208);
    chk("R6 pointer held, idx", cpu0_idx, 1);
    chk("R6 pointer held, ext", cpu0_ext, 1);

    wr(0, 0, 32'h1);
    wr(0, 1, 32'h0);
    stat('1);
    chk("R3 word0 bit0 is source 32", cpu0_idx, 32);
    rd(0, 0, r); chk("R3 word0 readback", r, 32'h1);
    rd(0, 1, r); chk("R3 word1 readback", r, 32'h0);

    wr(0, 1, 32'hffff_ffff);
    wr(1, 1, 32'hffff_ffff);
    op(0, 20, 2'b00);
    rd(0, 1, r); chk("R7 cpu0 bit cleared", r, 32'hffef_ffff);
    rd(1, 1, r); chk("R7 cpu1 bit cleared", r, 32'hffef_ffff);
    op(1, 20, 2'b10);
    rd(0, 1, r); chk("R8 cpu0 stays clear", r, 32'hffef_ffff);
    rd(1, 1, r); chk("R8 cpu1 set", r, 32'hffff_ffff);
    op(1, 20, 2'b01);
    rd(0, 1, r); chk("R8 cpu0 set", r, 32'hffff_ffff);
    rd(1, 1, r); chk("R8 cpu1 cleared", r, 32'hffef_ffff);
    stat(64'h0030_0000);
    chk("R1 cpu1 uses own mask", cpu1_idx, 21);

    @(negedge clk);
    reg_wr = 1; reg_cpu = 0; reg_word = 1; reg_wdata = 32'h0;
    op_valid = 1; op_unmask = 1; op_src = 2; op_cpu_en = 2'b01;
    @(negedge clk); reg_wr = 0; op_valid = 0;
    rd(0, 1, r); chk("R11 op wins its bit", r, 32'h4);

    @(negedge clk); s_wr = 1; s_cpu = 1; s_wdata = 32'hffff_ffff;
    @(negedge clk); s_cpu = 0; s_wdata = 32'h0002_0000;
    @(negedge clk); s_wr = 0; s_stat = '1;
    #2;
    chk("R10 absent bank no req", s_req1, 0);
    s_cpu = 1; #1;
    chk("R10 absent bank reads 0", s_rdata, 0);
    chk("R3 32-source word0 is source 17", {s_req0, s_idx0}, {1'b1, 5'd17});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule